// File: doc/BRIEF.md
# Shared Prescaler Tick Divider

This block turns a single peripheral clock into five count-enable strobes, one for each channel of a five-channel timer. The counters that consume the strobes sit outside the block. Two 8-bit prescalers are packed into one configuration word. Channels 0 and 1 draw on the low prescaler. Channels 2, 3 and 4 draw on the high prescaler. Behind its prescaler, each channel has its own power-of-two post-divider, picked by a 4-bit select field in a second configuration word.

Each prescaler is a free-running down-counter. It fires once every (value + 1) clock cycles. A post-divider counts these firings and lets one through every 2^select of them. A select above 4 is treated as 4. A new prescaler value takes effect only when the running count wraps. As a result, no strobe interval is cut short by a write. Software writes either word with a one-cycle write strobe. Both words are also brought out for readback.

Top module: `timer_tick_gen`

## Requirements
- R1: After reset the prescaler word reads 0x0101 and the select word reads 0.
- R2: A write strobe on either word loads the whole word on the next clock edge. Readback returns the written value, and the word holds while its strobe is low.
- R3: Channels 0 and 1 are timed by prescaler bits 7:0. Channels 2, 3 and 4 are timed by prescaler bits 15:8.
- R4: The select field of channel n is select-word bits 4n+3 down to 4n.
- R5: Once the configuration is settled, channel n's tick is high for one cycle every (P + 1) × 2^S cycles. P is its prescaler field and S is its select. The tick stays high continuously when that product is 1.
- R6: Any select value from 5 to 15 gives the same period as a select of 4, that is 16 prescaler firings.
- R7: A new prescaler value is loaded only when the running count wraps. The interval in progress when the write lands therefore completes at the old length, and the following intervals use the new length.
- R8: With the reset configuration, every channel ticks once every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_wr | input | 1 | Write strobe for the prescaler word |
| pre_wdata | input | 16 | New prescaler word: low byte for group A, high byte for group B |
| sel_wr | input | 1 | Write strobe for the select word |
| sel_wdata | input | 20 | New select word, 4 bits per channel |
| pre_rd | output | 16 | Current prescaler word |
| sel_rd | output | 20 | Current select word |
| tick | output | 5 | One-cycle count-enable strobe per channel |

## Verification
Any corrupted prescaler or post-divider count shows up as a wrong spacing between consecutive ticks on the affected channels. That error is visible within one tick period of the faulty state, which is at most 4096 cycles. A fault in a shared prescaler moves two or three channels at once. A fault in a post-divider moves only its own channel. The bench therefore measures every channel's tick intervals against the period worked out from its own copy of the configuration. It measures the transition after a prescaler write separately, to show that the interval already under way keeps its old length.

// File: rtl/tick_pkg.sv
`timescale 1ns/1ps
package tick_pkg;
    localparam int NUM_CH    = 5;   // timer channels
    localparam int NUM_GRP   = 2;   // shared prescalers
    localparam int GRP0_CH   = 2;   // channels [0, GRP0_CH) use group 0
    localparam int PRE_W     = 8;   // prescaler field width
    localparam int SEL_W     = 4;   // post-divider select width
    localparam int MAX_SHIFT = 4;   // largest post-divider exponent
endpackage

// File: rtl/tick_cfg_regs.sv
`timescale 1ns/1ps
module tick_cfg_regs #(
    parameter int NUM_GRP = 2,
    parameter int PRE_W   = 8,
    parameter int NUM_CH  = 5,
    parameter int SEL_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pre_wr,
    input  logic [NUM_GRP*PRE_W-1:0]   pre_wdata,
    input  logic                       sel_wr,
    input  logic [NUM_CH*SEL_W-1:0]    sel_wdata,
    output logic [NUM_GRP*PRE_W-1:0]   pre_q,
    output logic [NUM_CH*SEL_W-1:0]    sel_q
);
    localparam int PW = NUM_GRP * PRE_W;
    localparam int SW = NUM_CH * SEL_W;
    localparam logic [PW-1:0] PRE_RST = {NUM_GRP{PRE_W'(1)}};
    localparam logic [SW-1:0] SEL_RST = '0;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [SW-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (pre_wr) cfg_d.pre = pre_wdata;
        if (sel_wr) cfg_d.sel = sel_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.pre <= PRE_RST;
            cfg_q.sel <= SEL_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pre_q = cfg_q.pre;
    assign sel_q = cfg_q.sel;

    assert_pre_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_wr |=> $stable(pre_q));
    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(sel_q));
    assert_pre_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_wr |=> pre_q == $past(pre_wdata));
endmodule

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] reload_val,
    output logic             pulse
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign pulse = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (pulse) st_d.cnt = reload_val;     // new value only at wrap
        else       st_d.cnt = st_q.cnt - PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: the count is taken from the field only at a wrap
    assert_reload_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> st_q.cnt == $past(reload_val));
    assert_no_midway_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> st_q.cnt < $past(st_q.cnt));
endmodule

// File: rtl/tick_postdiv.sv
`timescale 1ns/1ps
module tick_postdiv #(
    parameter int SEL_W     = 4,
    parameter int MAX_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam logic [SEL_W-1:0] SHIFT_CAP = SEL_W'(MAX_SHIFT);

    typedef struct packed {
        logic [MAX_SHIFT-1:0] div;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [SEL_W-1:0]     shift;
    logic [MAX_SHIFT:0]   span;
    logic [MAX_SHIFT-1:0] last_idx;

    always_comb begin
        shift    = (sel > SHIFT_CAP) ? SHIFT_CAP : sel;
        span     = ({{MAX_SHIFT{1'b0}}, 1'b1} << shift) - 1'b1;
        last_idx = span[MAX_SHIFT-1:0];
    end

    // >= lets a shrinking select wrap at once instead of counting round
    assign tick = en_in && (st_q.div >= last_idx);

    always_comb begin
        st_d = st_q;
        if (en_in) begin
            if (tick) st_d.div = '0;
            else      st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |=> $stable(st_q.div));
    assert_restart_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> st_q.div == '0);
endmodule

// File: rtl/timer_tick_gen.sv
`timescale 1ns/1ps
module timer_tick_gen
    import tick_pkg::*;
#(
    parameter int CH      = NUM_CH,
    parameter int GRP     = NUM_GRP,
    parameter int SPLIT   = GRP0_CH,
    parameter int PW      = PRE_W,
    parameter int SW      = SEL_W,
    parameter int SHIFT_M = MAX_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pre_wr,
    input  logic [GRP*PW-1:0]   pre_wdata,
    input  logic                sel_wr,
    input  logic [CH*SW-1:0]    sel_wdata,
    output logic [GRP*PW-1:0]   pre_rd,
    output logic [CH*SW-1:0]    sel_rd,
    output logic [CH-1:0]       tick
);
    logic [GRP*PW-1:0] pre_q;
    logic [CH*SW-1:0]  sel_q;
    logic [GRP-1:0]    pre_pulse;

    tick_cfg_regs #(.NUM_GRP(GRP), .PRE_W(PW), .NUM_CH(CH), .SEL_W(SW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_wr    (pre_wr),
        .pre_wdata (pre_wdata),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .pre_q     (pre_q),
        .sel_q     (sel_q)
    );

    for (genvar g = 0; g < GRP; g++) begin : g_pre
        tick_prescaler #(.PRE_W(PW)) u_pre (
            .clk        (clk),
            .rst_n      (rst_n),
            .reload_val (pre_q[g*PW +: PW]),
            .pulse      (pre_pulse[g])
        );
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        localparam int SRC = (c < SPLIT) ? 0 : 1;
        tick_postdiv #(.SEL_W(SW), .MAX_SHIFT(SHIFT_M)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .en_in (pre_pulse[SRC]),
            .sel   (sel_q[c*SW +: SW]),
            .tick  (tick[c])
        );
        // R3: a channel can only tick on a firing of its own prescaler
        assert_group_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tick[c] |-> pre_pulse[SRC]);
    end

    assign pre_rd = pre_q;
    assign sel_rd = sel_q;
endmodule

// File: tb/timer_tick_gen_test.sv
`timescale 1ns/1ps
module timer_tick_gen_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        pre_wr = 0;
    logic [15:0] pre_wdata = '0;
    logic        sel_wr = 0;
    logic [19:0] sel_wdata = '0;
    logic [15:0] pre_rd;
    logic [19:0] sel_rd;
    logic [4:0]  tick;

    timer_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .pre_wr(pre_wr), .pre_wdata(pre_wdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .pre_rd(pre_rd),
        .sel_rd(sel_rd), .tick(tick)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_t [5];
    int nt [5];
    logic [15:0] sh_pre = 16'h0101;
    logic [19:0] sh_sel = '0;
    string cur_req = "R8";
    bit done = 0;

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(int ch);
        int p, s;
        p = (ch < 2) ? int'(sh_pre[7:0]) : int'(sh_pre[15:8]);
        s = int'(sh_sel[ch*4 +: 4]);
        if (s > 4) s = 4;
        return (p + 1) << s;
    endfunction

    // interval monitor: skips the first two ticks after each write
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            for (int c = 0; c < 5; c++) begin
                if (tick[c]) begin
                    if (nt[c] >= 2)
                        check((cyc - last_t[c]) == exp_period(c),
                              $sformatf("%s ch%0d period", cur_req, c),
                              cyc - last_t[c], exp_period(c));
                    last_t[c] = cyc;
                    nt[c]++;
                end
            end
        end
    end

    task automatic clear_epoch();
        for (int c = 0; c < 5; c++) nt[c] = 0;
    endtask

    task automatic write_cfg(bit do_pre, logic [15:0] p, bit do_sel, logic [19:0] s);
        @(posedge clk); #1;
        pre_wr = do_pre; pre_wdata = p;
        sel_wr = do_sel; sel_wdata = s;
        if (do_pre) sh_pre = p;
        if (do_sel) sh_sel = s;
        clear_epoch();
        @(posedge clk); #1;
        pre_wr = 0; sel_wr = 0;
        check(pre_rd == sh_pre, "R2 pre readback", int'(pre_rd), int'(sh_pre));
        check(sel_rd == sh_sel, "R2 sel readback", int'(sel_rd), int'(sh_sel));
    endtask

    task automatic wait_all(int n);
        bit ok;
        do begin
            @(negedge clk); #1;
            ok = 1;
            for (int c = 0; c < 5; c++) if (nt[c] < n) ok = 0;
        end while (!ok);
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int gap;
        logic [15:0] rp;
        logic [19:0] rs;
        void'($urandom(32'd20111));
        clear_epoch();
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        check(pre_rd == 16'h0101, "R1 pre reset", int'(pre_rd), 16'h0101);
        check(sel_rd == 20'h0, "R1 sel reset", int'(sel_rd), 0);
        cur_req = "R8";
        wait_all(5);

        // R6 clamp: select 15 everywhere
        cur_req = "R6";
        write_cfg(1, 16'h0200, 1, 20'hFFFFF);
        wait_all(4);
        // R6/R4: 4 and 5 agree, distinct fields per channel
        cur_req = "R4 R6";
        write_cfg(1, 16'h0301, 1, {4'hF, 4'h3, 4'h0, 4'h5, 4'h4});
        wait_all(4);
        // R3: large group B, small group A
        cur_req = "R3";
        write_cfg(1, 16'hFF00, 1, {4'h0, 4'h0, 4'h0, 4'h4, 4'h0});
        wait_all(4);
        // R5: product of one gives a continuous tick
        cur_req = "R5";
        write_cfg(1, 16'h0000, 1, 20'h0);
        wait_all(4);

        // R7: shorten prescaler A mid-interval
        cur_req = "R7";
        write_cfg(1, 16'h0109, 1, 20'h0);
        wait_all(3);
        do @(negedge clk); while (!tick[0]);
        repeat (3) @(posedge clk); #1;
        pre_wr = 1; pre_wdata = 16'h0102; sh_pre = 16'h0102; clear_epoch();
        @(posedge clk); #1;
        pre_wr = 0;
        gap = 3;
        do begin @(negedge clk); gap++; end while (!tick[0]);
        check(gap == 10, "R7 interval in progress keeps old length", gap, 10);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tick[0]);
        check(gap == 3, "R7 next interval uses new length", gap, 3);
        wait_all(3);

        // random mix, R3 R4 R5
        for (int i = 0; i < 12; i++) begin
            rp = {3'b0, 5'($urandom), 3'b0, 5'($urandom)};
            rs = 20'($urandom);
            cur_req = "R3 R4 R5";
            case ($urandom % 3)
                0: write_cfg(1, rp, 0, rs);
                1: write_cfg(0, rp, 1, rs);
                default: write_cfg(1, rp, 1, rs);
            endcase
            wait_all(4);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule